// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This core moves 8-bit samples from any time-slot of any receive stream to any time-slot of any transmit stream. There are 4 streams and 32 slots per frame. Each clock is one time-slot. In that clock, one sample from every receive stream is stored in a three-bank data store, and one connection word per transmit stream is read. That word selects the source stream and channel, and also selects the delay rule. It can instead put its own contents on the output, gate the output drive, or send the output back into the receive side of the same stream and slot.

Two delay rules are available per output channel. The variable rule uses the shortest legal path. The constant rule always moves a sample exactly two frames forward, so that multi-slot data keeps its frame alignment. The outputs come from registers: one parallel sample and one drive-enable flag per stream, tagged with the slot number they belong to.

Top module: `tsi_switch_core`

## Requirements
- R1: While rst is high, and on the first cycle after it, every tx_en bit and all of tx_data are 0. Reset clears the connection store to all-zero words and the data store to zero samples.
- R2: An internal slot counter starts at 0 after reset and advances once per clock, modulo 32. The bank index (frame number modulo 3) advances when the counter wraps. The results for the slot processed in one clock appear on the outputs after the next rising edge, with tx_slot equal to that slot.
- R3: Delay-select bit 7 = 0 (variable rule), for source channel c and destination slot d: if d >= c+3, the output is the sample received in the same frame. Otherwise it is the sample from the previous frame.
- R4: Delay-select bit 7 = 1 (constant rule): the output in frame f is the sample received in frame f-2, whatever the channel numbers are.
- R5: Processor-mode bit 8 = 1: the output sample is bits 7:0 of the connection word itself, not stored data.
- R6: Loopback bit 10 = 1 on the word of stream n, slot m: the switched value of transmit stream n, slot m is stored in place of the received sample of stream n, slot m. The value is taken before output gating.
- R7: tx_en[i] = (ode OR osb) AND the output-enable bit 9 of that slot's word.
- R8: When tx_en[i] is 0, tx_data lane i is 0.
- R9: A connection word written through cm_we/cm_strm/cm_chan/cm_word is used from the next clock on. Its layout is: bits 4:0 source channel, bits 6:5 source stream, bit 7 delay select, bit 8 processor mode, bit 9 output enable, bit 10 loopback.
- R10: Lane i of rx_data (bits 8i+7:8i) is the sample of receive stream i. Lane i of tx_data is transmit stream i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time-slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Current slot's received sample, one 8-bit lane per stream |
| ode | input | 1 | Global drive override; when high, all slots may drive |
| osb | input | 1 | Stand-by enable, used when ode is low |
| cm_we | input | 1 | Connection word write strobe |
| cm_strm | input | 2 | Transmit stream of the word being written |
| cm_chan | input | 5 | Transmit slot of the word being written |
| cm_word | input | 11 | Connection word |
| tx_data | output | 32 | Switched samples of the previous slot, one lane per stream |
| tx_en | output | 4 | Per-stream drive enable of the previous slot |
| tx_slot | output | 5 | Slot number the outputs belong to |

## Verification
A bank index that has drifted, or a wrong same-frame/previous-frame decision, shows up at tx_data as a sample from the wrong frame. The received data depend on the frame count, so the error appears at the first affected slot, one clock after that slot is processed. A corrupted connection word or broken loopback path shows up at the latest one frame later, when the consuming slot reads the value. Enable faults show up in the same clock on tx_en or as non-zero data on a gated lane.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NSTREAM = 4;
    localparam int NSLOT   = 32;
    localparam int WIDTH   = 8;
    localparam int NBANK   = 3;
    localparam int MIN_GAP = 3;
    localparam int CHAN_W  = $clog2(NSLOT);
    localparam int STRM_W  = $clog2(NSTREAM);
    localparam int BANK_W  = $clog2(NBANK);

    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [STRM_W-1:0] strm_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [WIDTH-1:0]  smp_t;

    typedef struct packed {
        logic  lpbk;
        logic  oe;
        logic  pc;
        logic  hold;
        strm_t src_strm;
        chan_t src_chan;
    } conn_t;

    localparam int CONN_W = $bits(conn_t);

    function automatic bank_t bank_after(bank_t b);
        return (b == bank_t'(NBANK-1)) ? '0 : bank_t'(b + 1'b1);
    endfunction

    function automatic bank_t bank_before(bank_t b);
        return (b == '0) ? bank_t'(NBANK-1) : bank_t'(b - 1'b1);
    endfunction
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output chan_t slot,
    output bank_t cur_bank,
    output bank_t prev_bank,
    output bank_t old_bank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            cur_bank <= '0;
        end else begin
            slot <= chan_t'(slot + 1'b1);
            if (slot == chan_t'(NSLOT-1))
                cur_bank <= bank_after(cur_bank);
        end
    end

    assign prev_bank = bank_before(cur_bank);
    assign old_bank  = bank_after(cur_bank);
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  strm_t                wr_strm,
    input  chan_t                wr_chan,
    input  conn_t                wr_word,
    input  chan_t                rd_chan,
    output conn_t [NSTREAM-1:0]  rd_word
);
    conn_t mem [NSTREAM][NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSTREAM; s++)
                for (int c = 0; c < NSLOT; c++)
                    mem[s][c] <= '0;
        end else if (we) begin
            mem[wr_strm][wr_chan] <= wr_word;
        end
    end

    for (genvar g = 0; g < NSTREAM; g++) begin : g_rd
        assign rd_word[g] = mem[g][rd_chan];
    end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bank_t               wr_bank,
    input  chan_t               wr_chan,
    input  smp_t  [NSTREAM-1:0] wr_data,
    input  bank_t [NSTREAM-1:0] rd_bank,
    input  strm_t [NSTREAM-1:0] rd_strm,
    input  chan_t [NSTREAM-1:0] rd_chan,
    output smp_t  [NSTREAM-1:0] rd_data
);
    smp_t mem [NBANK][NSTREAM][NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++)
                for (int s = 0; s < NSTREAM; s++)
                    for (int c = 0; c < NSLOT; c++)
                        mem[b][s][c] <= '0;
        end else begin
            for (int s = 0; s < NSTREAM; s++)
                mem[wr_bank][s][wr_chan] <= wr_data[s];
        end
    end

    for (genvar g = 0; g < NSTREAM; g++) begin : g_rd
        assign rd_data[g] = mem[rd_bank[g]][rd_strm[g]][rd_chan[g]];
    end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
    import tsi_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSTREAM*WIDTH-1:0]  rx_data,
    input  logic                      ode,
    input  logic                      osb,
    input  logic                      cm_we,
    input  logic [STRM_W-1:0]         cm_strm,
    input  logic [CHAN_W-1:0]         cm_chan,
    input  logic [CONN_W-1:0]         cm_word,
    output logic [NSTREAM*WIDTH-1:0]  tx_data,
    output logic [NSTREAM-1:0]        tx_en,
    output logic [CHAN_W-1:0]         tx_slot
);
    chan_t slot;
    bank_t cur_bank, prev_bank, old_bank;

    conn_t [NSTREAM-1:0] word;
    bank_t [NSTREAM-1:0] rd_bank;
    strm_t [NSTREAM-1:0] rd_strm;
    chan_t [NSTREAM-1:0] rd_chan;
    smp_t  [NSTREAM-1:0] rd_data;
    smp_t  [NSTREAM-1:0] sw_data;
    smp_t  [NSTREAM-1:0] wr_data;
    logic  [NSTREAM-1:0] en_c;
    logic                drive;

    tsi_timebase u_tb (
        .clk(clk), .rst(rst), .slot(slot),
        .cur_bank(cur_bank), .prev_bank(prev_bank), .old_bank(old_bank)
    );

    tsi_conn_mem u_cm (
        .clk(clk), .rst(rst), .we(cm_we),
        .wr_strm(cm_strm), .wr_chan(cm_chan), .wr_word(conn_t'(cm_word)),
        .rd_chan(slot), .rd_word(word)
    );

    tsi_data_mem u_dm (
        .clk(clk), .rst(rst),
        .wr_bank(cur_bank), .wr_chan(slot), .wr_data(wr_data),
        .rd_bank(rd_bank), .rd_strm(rd_strm), .rd_chan(rd_chan),
        .rd_data(rd_data)
    );

    assign drive = ode | osb;

    for (genvar g = 0; g < NSTREAM; g++) begin : g_lane
        logic [CHAN_W:0] reach;
        logic            same_frame;

        // source is already stored this frame only if it lies MIN_GAP slots back
        assign reach      = {1'b0, word[g].src_chan} + (CHAN_W+1)'(MIN_GAP);
        assign same_frame = ({1'b0, slot} >= reach);

        always_comb begin
            if (word[g].hold)
                rd_bank[g] = old_bank;
            else if (same_frame)
                rd_bank[g] = cur_bank;
            else
                rd_bank[g] = prev_bank;
        end

        assign rd_strm[g] = word[g].src_strm;
        assign rd_chan[g] = word[g].src_chan;
        assign sw_data[g] = word[g].pc ? smp_t'(word[g]) : rd_data[g];
        assign wr_data[g] = word[g].lpbk ? sw_data[g] : rx_data[g*WIDTH +: WIDTH];
        assign en_c[g]    = drive & word[g].oe;

        always_ff @(posedge clk) begin
            if (rst) begin
                tx_data[g*WIDTH +: WIDTH] <= '0;
                tx_en[g]                  <= 1'b0;
            end else begin
                tx_data[g*WIDTH +: WIDTH] <= en_c[g] ? sw_data[g] : '0;
                tx_en[g]                  <= en_c[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tx_slot <= '0;
        else     tx_slot <= slot;
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      ode,
    input logic                      osb,
    input logic [NSTREAM*WIDTH-1:0]  tx_data,
    input logic [NSTREAM-1:0]        tx_en,
    input logic [CHAN_W-1:0]         tx_slot,
    input bank_t                     cur_bank,
    input bank_t                     old_bank
);
    logic run1, run2;
    logic [NSTREAM*WIDTH-1:0] spill;

    always_ff @(posedge clk) begin
        if (rst) begin
            run1 <= 1'b0;
            run2 <= 1'b0;
        end else begin
            run1 <= 1'b1;
            run2 <= run1;
        end
    end

    always_comb begin
        for (int i = 0; i < NSTREAM; i++)
            spill[i*WIDTH +: WIDTH] = tx_en[i] ? '0 : tx_data[i*WIDTH +: WIDTH];
    end

    // R7
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en != '0) |-> $past(ode | osb));

    // R8
    gated_zero_chk: assert property (@(posedge clk) disable iff (rst)
        spill == '0);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        run2 |-> (tx_slot == chan_t'($past(tx_slot) + 1'b1)));

    // R2
    bank_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_bank < bank_t'(NBANK)) && (old_bank != cur_bank));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (tx_en == '0) && (tx_data == '0));
endmodule

bind tsi_switch_core tsi_switch_chk u_chk (
    .clk(clk), .rst(rst), .ode(ode), .osb(osb),
    .tx_data(tx_data), .tx_en(tx_en), .tx_slot(tx_slot),
    .cur_bank(cur_bank), .old_bank(old_bank)
);

// File: tb/sim_tsi_switch_core.sv
module sim_tsi_switch_core;
    import tsi_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                     rst;
    logic [NSTREAM*WIDTH-1:0] rx_data;
    logic                     ode, osb, cm_we;
    logic [STRM_W-1:0]        cm_strm;
    logic [CHAN_W-1:0]        cm_chan;
    logic [CONN_W-1:0]        cm_word;
    logic [NSTREAM*WIDTH-1:0] tx_data;
    logic [NSTREAM-1:0]       tx_en;
    logic [CHAN_W-1:0]        tx_slot;

    tsi_switch_core u0 (
        .clk(clk), .rst(rst), .rx_data(rx_data), .ode(ode), .osb(osb),
        .cm_we(cm_we), .cm_strm(cm_strm), .cm_chan(cm_chan), .cm_word(cm_word),
        .tx_data(tx_data), .tx_en(tx_en), .tx_slot(tx_slot)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [CONN_W-1:0] cm_m [NSTREAM][NSLOT];
    logic [WIDTH-1:0]  dm_m [NBANK][NSTREAM][NSLOT];
    int bslot, bbank, bframe;
    string ftag;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // word fields: [4:0] chan, [6:5] stream, [7] constant, [8] pc, [9] oe, [10] loopback (R9)
    function automatic logic [CONN_W-1:0] mk(input bit lp, input bit oe, input bit pc,
                                             input bit hold, input int st, input int ch);
        return {lp, oe, pc, hold, 2'(st), 5'(ch)};
    endfunction

    function automatic logic [CONN_W-1:0] cfg_word(input int cfg, input int st, input int ch);
        case (cfg)
            0: return mk(0, 1, 0, 0, (st + ch) % 4, (ch * 7 + st * 3) % 32);       // R3
            1: return mk(0, 1, 0, 1, (st + 3 * ch) % 4, (31 - ch + st) % 32);     // R4
            2: return mk(st == 0 && ch < 8, ch % 7 != 3, ch % 5 == 0, ch % 2,
                         3 - st, (ch + 5 * st) % 32);                               // R5 R6 R7
            default: return mk(0, 1, 0, 0, st, (ch + 30 - (ch % 2)) % 32);         // R3 boundary
        endcase
    endfunction

    task automatic step(input bit do_chk);
        logic [WIDTH-1:0] sw [NSTREAM];
        logic [WIDTH-1:0] ed [NSTREAM];
        logic             ee [NSTREAM];
        string            tg [NSTREAM];
        int               es;
        for (int i = 0; i < NSTREAM; i++)
            rx_data[i*WIDTH +: WIDTH] = 8'((bframe * 37 + i * 61 + bslot * 5 + 3) & 255);
        for (int i = 0; i < NSTREAM; i++) begin
            logic [CONN_W-1:0] w;
            int bk, sc, ss;
            w  = cm_m[i][bslot];
            sc = int'(w[4:0]);
            ss = int'(w[6:5]);
            if (w[7])                bk = (bbank + 1) % 3;
            else if (bslot >= sc + 3) bk = bbank;
            else                     bk = (bbank + 2) % 3;
            sw[i] = w[8] ? w[7:0] : dm_m[bk][ss][sc];
            ee[i] = (ode | osb) & w[9];
            ed[i] = ee[i] ? sw[i] : 8'h00;
            if (!ee[i])                 tg[i] = "R8";
            else if (w[8])              tg[i] = "R5";
            else if (cm_m[ss][sc][10])  tg[i] = "R6";
            else if (w[7])              tg[i] = "R4";
            else                        tg[i] = "R3";
            if (ftag != "") tg[i] = ftag;
        end
        for (int i = 0; i < NSTREAM; i++)
            dm_m[bbank][i][bslot] = cm_m[i][bslot][10] ? sw[i] : rx_data[i*WIDTH +: WIDTH];
        if (cm_we) cm_m[cm_strm][cm_chan] = cm_word;
        es = bslot;
        bslot++;
        if (bslot == NSLOT) begin
            bslot = 0;
            bbank = (bbank + 1) % 3;
            bframe++;
        end
        @(posedge clk);
        @(negedge clk);
        if (do_chk) begin
            chk("R2 slot", int'(tx_slot), es);
            for (int i = 0; i < NSTREAM; i++) begin
                chk({tg[i], " data"}, int'(tx_data[i*WIDTH +: WIDTH]), int'(ed[i]));
                chk("R7 en", int'(tx_en[i]), int'(ee[i]));
            end
        end
    endtask

    task automatic program_cfg(input int cfg);
        for (int s = 0; s < NSTREAM; s++)
            for (int c = 0; c < NSLOT; c++) begin
                cm_we = 1'b1; cm_strm = 2'(s); cm_chan = 5'(c);
                cm_word = cfg_word(cfg, s, c);
                step(0);
            end
        cm_we = 1'b0;
    endtask

    task automatic run_frames(input int n);
        for (int k = 0; k < n * NSLOT; k++) step(1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ode = 1'b0; osb = 1'b0; cm_we = 1'b0;
        cm_strm = '0; cm_chan = '0; cm_word = '0; rx_data = '0;
        ftag = "";
        bslot = 0; bbank = 0; bframe = 0;
        for (int s = 0; s < NSTREAM; s++)
            for (int c = 0; c < NSLOT; c++) begin
                cm_m[s][c] = '0;
                for (int b = 0; b < NBANK; b++) dm_m[b][s][c] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset en", int'(tx_en), 0);
        chk("R1 reset data", int'(tx_data), 0);
        rst = 1'b0;
        ode = 1'b1;
        // R1: cleared connection store keeps every slot disabled
        ftag = "R1";
        run_frames(1);
        ftag = "";
        // R3 / R10: variable delay sweep
        program_cfg(0);
        run_frames(3);
        // R9: overwrite the slot being processed, new word used from the next clock
        cm_we = 1'b1; cm_strm = 2'd2; cm_chan = 5'(bslot);
        cm_word = mk(0, 1, 1, 0, 1, 5'h05);
        step(1);
        cm_we = 1'b0;
        ftag = "R9";
        run_frames(1);
        ftag = "";
        // R3 boundary: source two or three slots behind the destination
        program_cfg(3);
        run_frames(3);
        // R4: constant delay sweep
        program_cfg(1);
        run_frames(4);
        // R5 R6 R7 R8: mixed controls under different drive settings
        program_cfg(2);
        run_frames(3);
        ode = 1'b0; osb = 1'b1;
        run_frames(2);
        osb = 1'b0;
        run_frames(1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule